// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block receives 8-bit characters from an idle-high asynchronous serial line. A falling edge arms a programmable 5-bit half-bit counter. After one half-bit the line is checked again to confirm the start bit. From then on the data bits arrive least significant first, followed by an optional parity bit and one stop bit. Each bit is sampled at its midpoint, once per full bit period.

A completed character moves from the shift register into a receive buffer that the bus side reads with a strobe. A sticky status word records parity, framing and overrun errors, and a second strobe clears it. At the end of every frame the block pulses exactly one of two outputs: a completion pulse for a clean frame, or an error pulse for a frame with any error.

The receiver starts only when power is enabled first and the receive enable then rises.

Top module: `serial_rx`

## Requirements
- R1: Reception becomes active only on a rising edge of `rx_en_i` while `pwr_en_i` is 1. If `rx_en_i` was already 1 when power came on, no frame is received until `rx_en_i` is dropped and raised again. Clearing either enable returns the receiver to idle.
- R2: A falling edge on the idle line starts verification. The line is sampled again after `div_i+1` clocks. If it is high by then, the event is discarded and no frame, pulse or status change results.
- R3: One bit period is `2*(div_i+1)` clocks. The eight data bits are taken least significant bit first and appear unchanged on `rx_data_o`.
- R4: At the end of a frame with no error, `done_o` pulses for exactly one clock, `rx_data_o` holds the new character in that same cycle, and `buf_full_o` is 1.
- R5: `par_mode_i` selects the parity check: 0 means no parity bit, 1 even, 2 odd, and 3 means the bit must be 0. A mismatch sets `stat_o[0]`. With mode 0 the stop bit directly follows bit 7.
- R6: A parity error or a stop bit sampled as 0 (which sets `stat_o[1]`) does not abort the frame. The character is still written to the buffer, and `err_o` pulses once at the end of the frame instead of `done_o`. `done_o` and `err_o` are never high together.
- R7: If a frame completes while `buf_full_o` is 1 and no buffer read occurs in that cycle, the buffer keeps its previous value, `stat_o[2]` (overrun) is set, and `err_o` pulses.
- R8: After reset, all outputs are 0. `rd_buf_i` clears `buf_full_o`, and `rd_stat_i` clears all three bits of `stat_o`.
- R9: Only one stop bit is checked. A new start bit that immediately follows the stop bit is received as a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_en_i | input | 1 | Power enable |
| rx_en_i | input | 1 | Receive enable; its rising edge arms the receiver while powered |
| div_i | input | 5 | Half-bit divisor; half-bit period is div_i+1 clocks |
| par_mode_i | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 forced zero |
| rxd_i | input | 1 | Serial line, idle high |
| rd_buf_i | input | 1 | Buffer read strobe |
| rd_stat_i | input | 1 | Status read strobe |
| rx_data_o | output | 8 | Receive buffer |
| stat_o | output | 3 | Sticky status: [0] parity, [1] framing, [2] overrun |
| buf_full_o | output | 1 | Buffer holds an unread character |
| done_o | output | 1 | One-clock pulse for a clean frame |
| err_o | output | 1 | One-clock pulse for a frame with any error |

## Verification
The hardest case to reach is an overrun caused by a second frame that starts right on the heels of the first stop bit. The bench holds off all buffer reads and sends two frames back to back with a single stop bit each. It then checks that the first character survives, that the overrun flag is set, and that an error pulse was counted for the second frame. A start glitch shorter than half a bit and an enable raised before power are also driven from the ports, and each is followed by an observation window in which no pulse or buffer fill may appear.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_ZERO = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic ove;
    logic fe;
    logic pe;
  } rx_stat_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= 1'b1;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/serial_rx_baud.sv
module serial_rx_baud #(
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             hit;

  assign hit    = cnt_q >= div_i;
  assign tick_o = run_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (hit)     cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i) |=> (!tick_o || div_i == '0)); // R3
endmodule

// File: rtl/serial_rx_fsm.sv
module serial_rx_fsm
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_en_i,
  input  logic              rx_en_i,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  par_mode_e         par_mode_i,
  output logic              run_o,
  output logic              frame_end_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pe_o,
  output logic              fe_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic              active_q, rx_en_q, line_q, phase_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              sample, par_bad;

  // arm only on rx_en rising while powered
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      active_q <= 1'b0;
      rx_en_q  <= 1'b0;
      line_q   <= 1'b1;
    end else begin
      rx_en_q <= rx_en_i;
      line_q  <= rxd_i;
      if (!pwr_en_i || !rx_en_i) active_q <= 1'b0;
      else if (!rx_en_q)         active_q <= 1'b1;
    end

  assign sample = tick_i && phase_q;
  assign run_o  = (state_q != ST_IDLE);

  always_comb begin
    unique case (par_mode_i)
      PAR_EVEN: par_bad = (^shreg_q) ^ rxd_i;
      PAR_ODD:  par_bad = ~((^shreg_q) ^ rxd_i);
      PAR_ZERO: par_bad = rxd_i;
      default:  par_bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      phase_q     <= 1'b0;
      idx_q       <= '0;
      shreg_q     <= '0;
      frame_end_o <= 1'b0;
      pe_o        <= 1'b0;
      fe_o        <= 1'b0;
    end else begin
      frame_end_o <= 1'b0;
      if (tick_i) phase_q <= ~phase_q;
      if (!active_q) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE:
            if (line_q && !rxd_i) state_q <= ST_START;
          ST_START:
            if (tick_i) begin
              phase_q <= 1'b0;
              idx_q   <= '0;
              pe_o    <= 1'b0;
              fe_o    <= 1'b0;
              state_q <= rxd_i ? ST_IDLE : ST_DATA;
            end
          ST_DATA:
            if (sample) begin
              shreg_q <= {rxd_i, shreg_q[DATA_W-1:1]};
              idx_q   <= idx_q + 1'b1;
              if (idx_q == LAST_IDX)
                state_q <= (par_mode_i == PAR_NONE) ? ST_STOP : ST_PAR;
            end
          ST_PAR:
            if (sample) begin
              pe_o    <= par_bad;
              state_q <= ST_STOP;
            end
          ST_STOP:
            if (sample) begin
              fe_o        <= ~rxd_i;
              frame_end_o <= 1'b1;
              state_q     <= ST_IDLE;
            end
          default: state_q <= ST_IDLE;
        endcase
      end
    end

  assign data_o = shreg_q;

  AST_OFF_GOES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_en_i && $past(!pwr_en_i)) |=> (state_q == ST_IDLE)); // R1
  AST_FALSE_START_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && rxd_i) |=> (state_q == ST_IDLE && !frame_end_o)); // R2
  AST_FRAME_END_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> !frame_end_o); // R4
endmodule

// File: rtl/serial_rx_regs.sv
module serial_rx_regs
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_end_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pe_i,
  input  logic              fe_i,
  input  logic              rd_buf_i,
  input  logic              rd_stat_i,
  output logic [DATA_W-1:0] buf_o,
  output logic              full_o,
  output rx_stat_t          stat_o,
  output logic              done_o,
  output logic              err_o
);
  logic     ovr_now;
  rx_stat_t fresh;

  // a read in the same cycle frees the slot first
  assign ovr_now   = frame_end_i && full_o && !rd_buf_i;
  assign fresh.ove = ovr_now;
  assign fresh.fe  = frame_end_i && fe_i;
  assign fresh.pe  = frame_end_i && pe_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      buf_o  <= '0;
      full_o <= 1'b0;
      stat_o <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (frame_end_i && !ovr_now) buf_o <= data_i;
      if (frame_end_i)   full_o <= 1'b1;
      else if (rd_buf_i) full_o <= 1'b0;
      stat_o <= rd_stat_i ? fresh : (stat_o | fresh);
      done_o <= frame_end_i && !(fresh.pe || fresh.fe || ovr_now);
      err_o  <= frame_end_i &&  (fresh.pe || fresh.fe || ovr_now);
    end

  AST_OVERRUN_KEEPS_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && full_o && !rd_buf_i) |=> ($stable(buf_o) && stat_o.ove && err_o)); // R7
  AST_DONE_ERR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R6
  AST_FRAME_FILLS_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> full_o); // R4
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_en_i,
  input  logic              rx_en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [1:0]        par_mode_i,
  input  logic              rxd_i,
  input  logic              rd_buf_i,
  input  logic              rd_stat_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [2:0]        stat_o,
  output logic              buf_full_o,
  output logic              done_o,
  output logic              err_o
);
  logic              rxd_s, run, tick, frame_end, pe, fe;
  logic [DATA_W-1:0] shreg;
  rx_stat_t          stat;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i, .rst_ni, .d_i(rxd_i), .q_o(rxd_s)
  );

  serial_rx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk_i, .rst_ni, .run_i(run), .div_i, .tick_o(tick)
  );

  serial_rx_fsm #(.DATA_W(DATA_W)) fsm_i (
    .clk_i, .rst_ni, .pwr_en_i, .rx_en_i, .rxd_i(rxd_s), .tick_i(tick),
    .par_mode_i(par_mode_e'(par_mode_i)), .run_o(run), .frame_end_o(frame_end),
    .data_o(shreg), .pe_o(pe), .fe_o(fe)
  );

  serial_rx_regs #(.DATA_W(DATA_W)) regs_i (
    .clk_i, .rst_ni, .frame_end_i(frame_end), .data_i(shreg), .pe_i(pe), .fe_i(fe),
    .rd_buf_i, .rd_stat_i, .buf_o(rx_data_o), .full_o(buf_full_o), .stat_o(stat),
    .done_o, .err_o
  );

  assign stat_o = stat;
endmodule

// File: tb/serial_rx_tb_top.sv
module serial_rx_tb_top;
  localparam int DIV = 7;
  localparam int BP  = 2 * (DIV + 1);

  typedef struct packed {
    logic [7:0] d;
    logic [1:0] m;
    logic       flip;
    logic       stop;
    logic       pe;
    logic       fe;
    logic       err;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'h5A, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h00, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'hFE, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{8'h81, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'h7F, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{8'h3C, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'hC3, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{8'h96, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{8'h01, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_en = 1'b0, rx_en = 1'b0, rxd = 1'b1, rd_buf = 1'b0, rd_stat = 1'b0;
  logic [1:0] par_mode = 2'd0;
  logic [7:0] rx_data;
  logic [2:0] stat;
  logic       buf_full, done, err;

  int total = 0, bad = 0, n_done = 0, n_err = 0;

  always #4 clk = ~clk;

  serial_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_en_i(pwr_en), .rx_en_i(rx_en), .div_i(5'(DIV)),
    .par_mode_i(par_mode), .rxd_i(rxd), .rd_buf_i(rd_buf), .rd_stat_i(rd_stat),
    .rx_data_o(rx_data), .stat_o(stat), .buf_full_o(buf_full), .done_o(done), .err_o(err)
  );

  always @(negedge clk) begin
    if (done) n_done++;
    if (err)  n_err++;
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] m, input logic flip,
                      input logic stop_v);
    logic p;
    rxd = 1'b0; hold(BP);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; hold(BP); end
    if (m != 2'd0) begin
      p = (m == 2'd1) ? ^d : (m == 2'd2) ? ~^d : 1'b0;
      rxd = p ^ flip; hold(BP);
    end
    rxd = stop_v; hold(BP);
    rxd = 1'b1;
  endtask

  task automatic read_all();
    rd_stat = 1'b1; hold(1); rd_stat = 1'b0;
    rd_buf  = 1'b1; hold(1); rd_buf  = 1'b0;
    hold(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d0, e0;
    hold(3);
    rst_n = 1'b1;
    hold(2); #1;
    // R8 reset state
    chk("R8 reset data", rx_data, 0);
    chk("R8 reset stat", stat, 0);
    chk("R8 reset full", buf_full, 0);
    chk("R8 reset pulses", {done, err}, 0);

    // R1 enable raised before power
    rx_en = 1'b1; hold(2);
    pwr_en = 1'b1; hold(2);
    d0 = n_done; e0 = n_err;
    send(8'hA5, 2'd0, 1'b0, 1'b1); hold(BP); #1;
    chk("R1 no rx before arm", {buf_full, 8'(n_done - d0), 8'(n_err - e0)}, 0);
    rx_en = 1'b0; hold(2); rx_en = 1'b1; hold(2);
    d0 = n_done;
    send(8'hA5, 2'd0, 1'b0, 1'b1); hold(BP); #1;
    chk("R1 rx after arm", {rx_data, 8'(n_done - d0)}, {8'hA5, 8'd1});
    read_all();

    // vector table: R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      par_mode = VEC[k].m; hold(2);
      d0 = n_done; e0 = n_err;
      send(VEC[k].d, VEC[k].m, VEC[k].flip, VEC[k].stop); hold(BP); #1;
      chk("R3 data lsb first", rx_data, VEC[k].d);
      chk("R5 R6 status", stat, {1'b0, VEC[k].fe, VEC[k].pe});
      chk("R4 R6 pulses", {8'(n_done - d0), 8'(n_err - e0)},
          {8'(!VEC[k].err), 8'(VEC[k].err)});
      chk("R4 buffer full", buf_full, 1);
      read_all();
    end
    par_mode = 2'd0;

    // R2 short glitch
    d0 = n_done; e0 = n_err;
    rxd = 1'b0; hold(3); rxd = 1'b1; hold(3 * BP); #1;
    chk("R2 glitch ignored", {buf_full, stat, 8'(n_done - d0), 8'(n_err - e0)}, 0);

    // R7 overrun
    send(8'h11, 2'd0, 1'b0, 1'b1); hold(BP);
    e0 = n_err;
    send(8'h22, 2'd0, 1'b0, 1'b1); hold(BP); #1;
    chk("R7 buffer kept", rx_data, 8'h11);
    chk("R7 overrun flag", stat, 3'b100);
    chk("R7 error pulse", n_err - e0, 1);
    rd_stat = 1'b1; hold(1); rd_stat = 1'b0; hold(1); #1;
    chk("R8 stat read clears", {stat, buf_full}, 4'b0001);
    rd_buf = 1'b1; hold(1); rd_buf = 1'b0; hold(1); #1;
    chk("R8 buf read clears", buf_full, 0);

    // R9 back-to-back frames with one stop bit
    d0 = n_done; e0 = n_err;
    send(8'h3C, 2'd0, 1'b0, 1'b1);
    send(8'hC3, 2'd0, 1'b0, 1'b1); hold(BP); #1;
    chk("R9 first kept", rx_data, 8'h3C);
    chk("R9 second seen", {8'(n_done - d0), 8'(n_err - e0), 5'd0, stat}, {8'd1, 8'd1, 8'd4});
    read_all();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule